// File: doc/BRIEF.md
# SPI Byte-Addressed Memory Target

This block is a byte-organised memory that answers as a target on an SPI bus. The host drives chip select, serial clock and serial data in. The block returns serial data out together with an output-enable that stands in for a tri-state driver. A hold input pauses a transfer part-way through a command without deselecting the block. A write-protect input gates writes to the status register. Every SPI input is brought into the block's system clock domain through a synchroniser. Clock edges are found by comparing successive synchronised samples, so the serial clock must run several times slower than the system clock.

A command opens with an 8-bit opcode. Memory commands then take a 16-bit address, most significant bit first, followed by any number of data bytes. The address steps up after each byte and wraps from the top of the array back to zero. Writes land in the array the moment the last bit of a byte arrives, so there is never a busy period. A status register holds a write-enable latch and two block-protect bits. The array is a synchronous RAM of `2**ADDR_BITS` bytes. Setting `ADDR_BITS` to 15 gives 32768 bytes. The default is kept small.

The command decoder has these states:
- `S_IDLE`: deselected.
- `S_OPCODE`: collecting the opcode.
- `S_ADDR_HI`, `S_ADDR_LO`: collecting the two address bytes.
- `S_RD_DATA`, `S_WR_DATA`: streaming memory data out or in.
- `S_RD_STAT`, `S_WR_STAT`: status read or write.
- `S_DRAIN`: ignoring the rest of a finished or unknown command.

The transitions are:
- Any state goes to `S_IDLE` when chip select is high.
- `S_IDLE` and `S_OPCODE` go on a completed opcode to `S_ADDR_HI` (read or write), `S_RD_STAT`, `S_WR_STAT` or `S_DRAIN` (latch set/clear and unknown codes).
- `S_ADDR_HI` goes to `S_ADDR_LO` after one byte.
- `S_ADDR_LO` goes to `S_RD_DATA` or `S_WR_DATA` after one byte.
- `S_WR_STAT` goes to `S_DRAIN` after one byte.

Top module: `spi_nvram_target`

## Requirements
- R1: Input bits are taken on rising serial-clock edges and the output bit changes only on falling edges. This works both when the clock idles low and when it idles high at chip-select fall (SPI modes 0 and 3).
- R2: Opcodes are 0x06 (set write-enable latch), 0x04 (clear latch), 0x05 (read status), 0x01 (write status), 0x03 (read memory) and 0x02 (write memory). The status byte reads bit 1 as the latch, bits 3:2 as block-protect, and all other bits as 0. It repeats for as long as the clock runs.
- R3: While chip select is high, `spi_sdo_oe` is 0 and serial clock and data activity has no effect. Every command is decoded from the first byte after chip select falls.
- R4: The 16-bit address is sent MSB first, and bits at or above `ADDR_BITS` are ignored. A read streams successive bytes with the address wrapping from `2**ADDR_BITS-1` to 0.
- R5: A written byte is readable by the very next command, with no busy wait. A write burst increments and wraps its address the same way as a read.
- R6: Memory and status writes take effect only while the latch is set. The latch clears when chip select rises after a write-memory or write-status opcode.
- R7: While hold is low, `spi_sdo_oe` is 0 and clock and data are ignored. Once hold returns high the transfer continues from the exact bit where it paused.
- R8: While write-protect is low, a status write leaves the block-protect bits unchanged.
- R9: Block-protect 01, 10 and 11 make memory writes have no effect in the top quarter, the top half and the whole array respectively. 00 protects nothing.
- R10: If chip select rises before a byte is complete, that partial byte is discarded and the next command decodes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sck | input | 1 | Serial clock |
| spi_sdi | input | 1 | Serial data from host |
| spi_hold_n | input | 1 | Hold, active low, pauses the transfer |
| spi_wp_n | input | 1 | Write-protect for status register, active low |
| spi_sdo | output | 1 | Serial data to host |
| spi_sdo_oe | output | 1 | Output enable for spi_sdo (0 means high impedance) |

## Verification
A 256-byte array is filled by one write burst that starts mid-array and wraps. It is then read back by one burst whose address carries junk upper bits, so the data pattern tells apart a wrong increment, a missed wrap and an address that failed to mask. Short reads and writes repeat in the idle-high clock mode to separate edge handling between the two SPI modes. All four block-protect codes are crossed with probe addresses in each quarter, which exposes a wrong region boundary. Reads and writes paused mid-byte by hold, a byte cut short by deselect, and status writes with the protect pin low each show whether the bit position, the latch and the protect bits survive.

// File: rtl/nvspi_pkg.sv
package nvspi_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_OPCODE,
        S_ADDR_HI,
        S_ADDR_LO,
        S_RD_DATA,
        S_WR_DATA,
        S_RD_STAT,
        S_WR_STAT,
        S_DRAIN
    } cmd_state_t;

    localparam logic [7:0] OP_SET_WEL = 8'h06;
    localparam logic [7:0] OP_CLR_WEL = 8'h04;
    localparam logic [7:0] OP_RD_STAT = 8'h05;
    localparam logic [7:0] OP_WR_STAT = 8'h01;
    localparam logic [7:0] OP_READ    = 8'h03;
    localparam logic [7:0] OP_WRITE   = 8'h02;

endpackage

// File: rtl/nvspi_in_sync.sv
module nvspi_in_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    input  logic sdi,
    input  logic hold_n,
    input  logic wp_n,
    output logic sel,
    output logic hold_ok,
    output logic wp_ok,
    output logic sdi_s,
    output logic sck_rise,
    output logic sck_fall
);
    // bundle order: {wp_n, hold_n, cs_n, sck, sdi}
    localparam int         NSIG      = 5;
    localparam logic [4:0] RST_LEVEL = 5'b11100;

    logic [NSIG-1:0] pipe [SYNC_STAGES];
    logic [NSIG-1:0] synced;
    logic            sck_prev;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < SYNC_STAGES; i++) pipe[i] <= RST_LEVEL;
            sck_prev <= 1'b0;
        end else begin
            pipe[0] <= {wp_n, hold_n, cs_n, sck, sdi};
            for (int i = 1; i < SYNC_STAGES; i++) pipe[i] <= pipe[i-1];
            sck_prev <= synced[1];
        end
    end

    assign synced   = pipe[SYNC_STAGES-1];
    assign wp_ok    = synced[4];
    assign hold_ok  = synced[3];
    assign sel      = ~synced[2];
    assign sdi_s    = synced[0];
    assign sck_rise = synced[1] & ~sck_prev & sel & hold_ok;
    assign sck_fall = ~synced[1] & sck_prev & sel & hold_ok;

endmodule

// File: rtl/nvspi_array.sv
module nvspi_array #(
    parameter int ADDR_BITS = 11
) (
    input  logic                 clk,
    input  logic                 we,
    input  logic                 re,
    input  logic [ADDR_BITS-1:0] addr,
    input  logic [7:0]           wdata,
    output logic [7:0]           rdata
);
    localparam int DEPTH = 1 << ADDR_BITS;

    logic [7:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[addr] <= wdata;
        if (re) rdata <= cells[addr];
    end

endmodule

// File: rtl/nvspi_cmd_fsm.sv
module nvspi_cmd_fsm
    import nvspi_pkg::*;
#(
    parameter int ADDR_BITS = 11
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sel,
    input  logic                 hold_ok,
    input  logic                 wp_ok,
    input  logic                 sdi_s,
    input  logic                 sck_rise,
    input  logic                 sck_fall,
    output logic                 sdo,
    output logic                 sdo_oe,
    output logic                 mem_we,
    output logic                 mem_re,
    output logic [ADDR_BITS-1:0] mem_addr,
    output logic [7:0]           mem_wdata,
    input  logic [7:0]           mem_rdata
);
    cmd_state_t           state, state_nxt;
    logic [2:0]           bit_cnt;
    logic [6:0]           rx_sr;
    logic [7:0]           byte_in;
    logic                 byte_done;
    logic [7:0]           addr_hi;
    logic [15:0]          full_addr;
    logic [ADDR_BITS-1:0] rx_addr;
    logic [ADDR_BITS-1:0] ptr;
    logic                 wel;
    logic [1:0]           bp;
    logic                 wr_cmd;
    logic                 op_write;
    logic [6:0]           tx_sr;
    logic                 sdo_q;
    logic [7:0]           status_byte;
    logic [7:0]           tx_src;
    logic                 streaming;
    logic                 unused_addr_bits;

    function automatic logic blk_prot(input logic [1:0] b, input logic [ADDR_BITS-1:0] a);
        unique case (b)
            2'b00: blk_prot = 1'b0;
            2'b01: blk_prot = (a[ADDR_BITS-1:ADDR_BITS-2] == 2'b11);
            2'b10: blk_prot = a[ADDR_BITS-1];
            default: blk_prot = 1'b1;
        endcase
    endfunction

    assign byte_in          = {rx_sr, sdi_s};
    assign byte_done        = sck_rise && (bit_cnt == 3'd7);
    assign full_addr        = {addr_hi, byte_in};
    assign rx_addr          = full_addr[ADDR_BITS-1:0];
    assign unused_addr_bits = ^full_addr;
    assign status_byte      = {4'b0000, bp, wel, 1'b0};
    assign streaming        = (state == S_RD_DATA) || (state == S_RD_STAT);
    assign tx_src           = (state == S_RD_STAT) ? status_byte : mem_rdata;

    // ---------------- next state ----------------
    always_comb begin
        state_nxt = state;
        if (!sel) begin
            state_nxt = S_IDLE;
        end else begin
            unique case (state)
                S_IDLE, S_OPCODE: begin
                    state_nxt = S_OPCODE;
                    if (byte_done) begin
                        unique case (byte_in)
                            OP_READ, OP_WRITE: state_nxt = S_ADDR_HI;
                            OP_RD_STAT:        state_nxt = S_RD_STAT;
                            OP_WR_STAT:        state_nxt = S_WR_STAT;
                            default:           state_nxt = S_DRAIN;
                        endcase
                    end
                end
                S_ADDR_HI: if (byte_done) state_nxt = S_ADDR_LO;
                S_ADDR_LO: if (byte_done) state_nxt = op_write ? S_WR_DATA : S_RD_DATA;
                S_WR_STAT: if (byte_done) state_nxt = S_DRAIN;
                S_RD_DATA, S_WR_DATA, S_RD_STAT, S_DRAIN: state_nxt = state;
                default: state_nxt = S_IDLE;
            endcase
        end
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nxt;
    end

    // ---------------- datapath and outputs ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt  <= '0;
            rx_sr    <= '0;
            addr_hi  <= '0;
            ptr      <= '0;
            wel      <= 1'b0;
            bp       <= 2'b00;
            wr_cmd   <= 1'b0;
            op_write <= 1'b0;
            tx_sr    <= '0;
            sdo_q    <= 1'b0;
        end else if (!sel) begin
            bit_cnt <= '0;
            wr_cmd  <= 1'b0;
            if (wr_cmd) wel <= 1'b0;
        end else begin
            if (sck_rise) begin
                bit_cnt <= bit_cnt + 3'd1;
                rx_sr   <= byte_in[6:0];
            end
            if (byte_done) begin
                unique case (state)
                    S_IDLE, S_OPCODE: begin
                        op_write <= (byte_in == OP_WRITE);
                        if (byte_in == OP_SET_WEL) wel <= 1'b1;
                        if (byte_in == OP_CLR_WEL) wel <= 1'b0;
                        if (byte_in == OP_WRITE || byte_in == OP_WR_STAT) wr_cmd <= 1'b1;
                    end
                    S_ADDR_HI: addr_hi <= byte_in;
                    S_ADDR_LO: ptr <= op_write ? rx_addr : rx_addr + 1'b1;
                    S_RD_DATA, S_WR_DATA: ptr <= ptr + 1'b1;
                    S_WR_STAT: if (wel && wp_ok) bp <= byte_in[3:2];
                    default: ;
                endcase
            end
            if (sck_fall && streaming) begin
                if (bit_cnt == 3'd0) begin
                    sdo_q <= tx_src[7];
                    tx_sr <= tx_src[6:0];
                end else begin
                    sdo_q <= tx_sr[6];
                    tx_sr <= {tx_sr[5:0], 1'b0};
                end
            end
        end
    end

    always_comb begin
        sdo       = sdo_q;
        sdo_oe    = sel && hold_ok && streaming;
        mem_re    = byte_done && (((state == S_ADDR_LO) && !op_write) || (state == S_RD_DATA));
        mem_we    = byte_done && (state == S_WR_DATA) && wel && !blk_prot(bp, ptr);
        mem_addr  = (state == S_ADDR_LO) ? rx_addr : ptr;
        mem_wdata = byte_in;
    end

    // ---------------- assertions ----------------
    assert_idle_when_deselected_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |=> (state == S_IDLE));

    assert_hold_freezes_bits_R7: assert property (@(posedge clk) disable iff (!rst_n || !sel)
        !hold_ok |=> ($stable(bit_cnt) && $stable(rx_sr) && $stable(sdo_q)));

    assert_wp_keeps_protect_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !wp_ok |=> $stable(bp));

    assert_wel_drops_after_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == S_WR_DATA) && !sel) |=> !wel);

    assert_sdo_moves_on_fall_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sdo_q) |-> $past(sck_fall));

endmodule

// File: rtl/spi_nvram_target.sv
module spi_nvram_target #(
    parameter int ADDR_BITS   = 11,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic spi_cs_n,
    input  logic spi_sck,
    input  logic spi_sdi,
    input  logic spi_hold_n,
    input  logic spi_wp_n,
    output logic spi_sdo,
    output logic spi_sdo_oe
);
    logic                 sel, hold_ok, wp_ok, sdi_s, sck_rise, sck_fall;
    logic                 mem_we, mem_re;
    logic [ADDR_BITS-1:0] mem_addr;
    logic [7:0]           mem_wdata, mem_rdata;

    nvspi_in_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .cs_n(spi_cs_n), .sck(spi_sck), .sdi(spi_sdi),
        .hold_n(spi_hold_n), .wp_n(spi_wp_n),
        .sel(sel), .hold_ok(hold_ok), .wp_ok(wp_ok), .sdi_s(sdi_s),
        .sck_rise(sck_rise), .sck_fall(sck_fall)
    );

    nvspi_cmd_fsm #(.ADDR_BITS(ADDR_BITS)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .sel(sel), .hold_ok(hold_ok), .wp_ok(wp_ok), .sdi_s(sdi_s),
        .sck_rise(sck_rise), .sck_fall(sck_fall),
        .sdo(spi_sdo), .sdo_oe(spi_sdo_oe),
        .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    nvspi_array #(.ADDR_BITS(ADDR_BITS)) u_array (
        .clk(clk), .we(mem_we), .re(mem_re), .addr(mem_addr),
        .wdata(mem_wdata), .rdata(mem_rdata)
    );

    assert_quiet_output_R3: assert property (@(posedge clk) disable iff (!rst_n)
        spi_sdo_oe |-> (sel && hold_ok));

    assert_no_write_while_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |-> !mem_we);

endmodule

// File: tb/spi_nvram_target_test.sv
`timescale 1ns/1ps
module spi_nvram_target_test;
    localparam int AW   = 8;
    localparam int SIZE = 1 << AW;
    localparam int HALF = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, sck = 1'b0, sdi = 1'b0, hold_n = 1'b1, wp_n = 1'b1;
    logic sdo, sdo_oe;

    int compared = 0, mismatched = 0;
    bit mode3 = 1'b0;
    bit done = 1'b0;
    logic [7:0] model [SIZE];
    logic [1:0] bp_m = 2'b00;

    always #2.5 clk = ~clk;

    spi_nvram_target #(.ADDR_BITS(AW)) uut (
        .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sck(sck), .spi_sdi(sdi),
        .spi_hold_n(hold_n), .spi_wp_n(wp_n), .spi_sdo(sdo), .spi_sdo_oe(sdo_oe)
    );

    task automatic wait_clk(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(input string tag, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int a);
        return 8'((a * 37 + 11) & 255);
    endfunction

    function automatic bit prot(input logic [1:0] b, input int a);
        case (b)
            2'b01: return a >= (SIZE * 3) / 4;
            2'b10: return a >= SIZE / 2;
            2'b11: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    task automatic cs_on;
        sck = mode3;
        wait_clk(3);
        cs_n = 1'b0;
        wait_clk(4);
    endtask

    task automatic cs_off;
        if (!mode3) begin
            sck = 1'b0;
            wait_clk(HALF);
        end
        cs_n = 1'b1;
        wait_clk(6);
    endtask

    task automatic xfer(input logic [7:0] tx, input int hold_bit, output logic [7:0] rx);
        for (int i = 7; i >= 0; i--) begin
            if (hold_bit == 7 - i) begin
                sck = 1'b0;
                wait_clk(3);
                hold_n = 1'b0;
                wait_clk(4);
                check("R7 output released during hold", int'(sdo_oe), 0);
                for (int k = 0; k < 3; k++) begin
                    sck = 1'b1; sdi = ~sdi; wait_clk(3);
                    sck = 1'b0; wait_clk(3);
                end
                hold_n = 1'b1;
                wait_clk(4);
            end
            sck = 1'b0;
            sdi = tx[i];
            wait_clk(HALF);
            rx[i] = sdo;
            sck = 1'b1;
            wait_clk(HALF);
        end
    endtask

    task automatic op_only(input logic [7:0] op);
        logic [7:0] d;
        cs_on; xfer(op, -1, d); cs_off;
    endtask

    task automatic rd_status(output logic [7:0] st);
        logic [7:0] d;
        cs_on; xfer(8'h05, -1, d); xfer(8'h00, -1, st); cs_off;
    endtask

    task automatic wr_status(input logic [7:0] v);
        logic [7:0] d;
        cs_on; xfer(8'h01, -1, d); xfer(v, -1, d); cs_off;
    endtask

    task automatic addr_phase(input logic [7:0] op, input logic [15:0] a);
        logic [7:0] d;
        xfer(op, -1, d); xfer(a[15:8], -1, d); xfer(a[7:0], -1, d);
    endtask

    // single-byte write with model update; wel_set says whether latch was set first
    task automatic wr_one(input logic [15:0] a, input logic [7:0] v, input bit wel_set, input int hold_bit);
        logic [7:0] d;
        if (wel_set) op_only(8'h06);
        cs_on; addr_phase(8'h02, a); xfer(v, hold_bit, d); cs_off;
        if (wel_set && !prot(bp_m, int'(a) % SIZE)) model[int'(a) % SIZE] = v;
    endtask

    task automatic rd_check(input string tag, input logic [15:0] a, input int n, input int hold_bit);
        logic [7:0] d;
        cs_on; addr_phase(8'h03, a);
        for (int k = 0; k < n; k++) begin
            xfer(8'h00, (k == 0) ? hold_bit : -1, d);
            check(tag, int'(d), int'(model[(int'(a) + k) % SIZE]));
        end
        cs_off;
    endtask

    initial begin
        logic [7:0] st, d;
        wait_clk(5);
        check("R3 reset output enable", int'(sdo_oe), 0);
        rst_n = 1'b1;
        wait_clk(5);
        check("R3 idle output enable", int'(sdo_oe), 0);

        // R2 status and latch
        rd_status(st); check("R2 status after reset", int'(st), 8'h00);
        op_only(8'h06); rd_status(st); check("R2 latch set", int'(st), 8'h02);
        cs_on; xfer(8'h05, -1, d); xfer(8'h00, -1, st); check("R2 status repeats a", int'(st), 8'h02);
        xfer(8'h00, -1, st); check("R2 status repeats b", int'(st), 8'h02); cs_off;
        op_only(8'h04); rd_status(st); check("R2 latch cleared", int'(st), 8'h00);

        // R5 full wrapping write burst starting at 0x10
        op_only(8'h06);
        cs_on; addr_phase(8'h02, 16'h0010);
        for (int k = 0; k < SIZE; k++) begin
            xfer(pat((16 + k) % SIZE), -1, d);
            model[(16 + k) % SIZE] = pat((16 + k) % SIZE);
        end
        cs_off;
        rd_status(st); check("R6 latch cleared after write", int'(st), 8'h00);

        // R4 full read with junk upper address bits, wrapping
        rd_check("R4 wrap read", 16'hABF0, SIZE, -1);

        // R1 mode 3 read and write
        mode3 = 1'b1;
        rd_check("R1 mode3 read", 16'h007C, 8, -1);
        wr_one(16'h0021, 8'h3C, 1'b1, -1);
        mode3 = 1'b0;
        rd_check("R1 mode3 write seen in mode0", 16'h0021, 1, -1);

        // R6 write without latch ignored
        wr_one(16'h0020, 8'hA5, 1'b0, -1);
        rd_check("R6 no latch no write", 16'h0020, 1, -1);

        // R5 back-to-back write then read
        wr_one(16'h0030, 8'h11, 1'b1, -1);
        rd_check("R5 immediate readback", 16'h0030, 1, -1);

        // R10 partial byte discarded
        op_only(8'h06);
        cs_on; addr_phase(8'h02, 16'h0040);
        for (int i = 0; i < 5; i++) begin
            sck = 1'b0; sdi = 1'b1; wait_clk(HALF); sck = 1'b1; wait_clk(HALF);
        end
        cs_off;
        rd_check("R10 partial byte dropped", 16'h0040, 1, -1);
        rd_status(st); check("R10 next command decodes", int'(st), 8'h00);

        // R3 activity while deselected
        for (int i = 0; i < 10; i++) begin
            sck = ~sck; sdi = ~sdi; wait_clk(3);
            if (i == 5) check("R3 no output while deselected", int'(sdo_oe), 0);
        end
        sck = 1'b0;
        wait_clk(3);
        rd_check("R3 memory untouched", 16'h0040, 2, -1);

        // R8 write-protect pin
        wp_n = 1'b0;
        op_only(8'h06); wr_status(8'h0C);
        rd_status(st); check("R8 protect bits held", int'(st), 8'h00);
        wp_n = 1'b1;
        wr_status(8'h0C);
        rd_status(st); check("R6 status write needs latch", int'(st), 8'h00);

        // R9 block-protect sweep
        for (int b = 0; b < 4; b++) begin
            op_only(8'h06); wr_status(8'(b << 2));
            bp_m = 2'(b);
            rd_status(st); check("R9 protect bits", int'(st), b << 2);
            for (int j = 0; j < 4; j++) begin
                wr_one(16'(j * 64 + 63), 8'(8'h80 + b * 16 + j), 1'b1, -1);
                rd_check("R9 region write", 16'(j * 64 + 63), 1, -1);
            end
        end
        op_only(8'h06); wr_status(8'h00); bp_m = 2'b00;

        // R7 hold during read and write
        rd_check("R7 read resumes after hold", 16'h0050, 2, 3);
        wr_one(16'h0060, 8'hC6, 1'b1, 5);
        rd_check("R7 write resumes after hold", 16'h0060, 1, -1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule